// File: doc/BRIEF.md
# Six-pin GPIO port with peripheral override

This block is a small memory-mapped general-purpose I/O port. It has six pins. Pins 0 to 4 are bidirectional. Pin 5 can only be an input. Software works the port through three registers on a simple register bus:

- a direction register, where a 1 makes a pin an input;
- an output latch, which holds the value driven on output pins;
- a port register, which reads back the pin levels after they pass through a synchroniser.

The block produces per-pin pad controls, an output enable and an output value, and it samples the pad inputs.

A peripheral can take over pins 0 to 2. An example is a CAN controller whose transmit data leaves on pin 0. The peripheral raises a per-pin override request and supplies its own direction and data. These override signals act only on the path to the pad. The stored direction bits never change, so software can read-modify-write the direction register safely while a peripheral owns some of the pins. The latch register always returns what software stored, not the pin level. Read-modify-write of the outputs therefore works on latched values.

Pin 5 shares its pad with a master-clear function. A configuration input selects which function pin 5 has. When master clear is enabled, pin 5 reads as 0 in the port register.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted, the direction register reads 0x3F, the latch reads 0x00, and every pad output enable is 0, so all pins are inputs.
- R2: With no override active, pad_oe[i] is 1 exactly when direction bit i is 0, and pad_out[i] equals latch bit i.
- R3: A write to address 0 (port) or address 1 (latch) loads bits 4:0 of the write data into the latch. Reading address 1 returns the latch contents, whatever the pin levels are.
- R4: Reading address 0 returns pad_in as it was sampled two rising clock edges earlier. Bits 7:6 of every read are 0.
- R5: On pins 0 to 2, while ovr_req[i] is 1, pad_oe[i] equals ovr_oe[i] and pad_out[i] equals ovr_out[i]. The direction register read back at address 2 is not changed by the override.
- R6: ovr_req on pins 3, 4 and 5 has no effect. Those pins keep the register-driven pad controls.
- R7: Pin 5 is input-only. pad_oe[5] and pad_out[5] are always 0. Write data bit 5 is ignored for both the latch and the direction register, so latch bit 5 reads 0 and direction bit 5 reads 1.
- R8: When mclr_en is 1, bit 5 of a port read is 0. When mclr_en is 0, bit 5 carries the synchronised level of pad_in[5].
- R9: Address 3 reads as 0x00, and a write to address 3 changes no register.
- R10: A register write takes effect at the rising clock edge where wr_en is sampled high. Before that edge, reads return the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| mclr_en | input | 1 | 1 gives pin 5 to master clear, so its port bit reads 0 |
| ovr_req | input | 6 | Per-pin peripheral override request |
| ovr_oe | input | 6 | Peripheral output enable, 1 means drive |
| ovr_out | input | 6 | Peripheral output value |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Pad output enable, 1 means drive |
| pad_out | output | 6 | Pad output value |

## Verification
The bench runs random register writes, override patterns and pin levels together. It targets the corners below.

- **Overrides must not reach the direction register.** A design that wrote an override into the stored bits would read back a changed direction register.
- **Overrides only on pins 0 to 2.** A design that honoured requests on pins 3 to 5 would show the peripheral's value on those pads.
- **Pin 5 stays input-only and obeys master clear.** A design that let writes reach bit 5 would drive pin 5, or read a latch value for it. A design that ignored mclr_en would leak the pad level into bit 5 of port reads.
- **Read timing.** Directed cycles check the two-edge delay of port reads and the one-edge write latency. A design with one synchroniser stage too few or too many would return the new level one edge early or late. Writes and reads at the unused address 3 must leave everything unchanged.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;
   localparam int BUS_W = 8;
   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_PORT = 2'd0,
      SEL_LAT  = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      PIN_PLAIN   = 2'd0,
      PIN_SHARED  = 2'd1,
      PIN_IN_ONLY = 2'd2
   } pin_kind_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
`timescale 1ns/1ps
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int          NPINS        = 6,
   parameter logic [7:0]  IN_ONLY_MASK = 8'h20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    addr,
   input  logic [BUS_W-1:0]    wr_data,
   output logic [NPINS-1:0]    lat_q,
   output logic [NPINS-1:0]    dir_q
);
   localparam logic [NPINS-1:0] IN_ONLY = IN_ONLY_MASK[NPINS-1:0];
   localparam logic [NPINS-1:0] WR_OK   = ~IN_ONLY;

   reg_sel_e            sel;
   logic                lat_wr;
   logic                dir_wr;
   logic [NPINS-1:0]    wd;

   assign sel    = reg_sel_e'(addr);
   assign lat_wr = wr_en && (sel == SEL_PORT || sel == SEL_LAT);
   assign dir_wr = wr_en && (sel == SEL_DIR);
   assign wd     = wr_data[NPINS-1:0];

   generate
      if (NPINS < BUS_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^wr_data[BUS_W-1:NPINS];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (lat_wr) begin
         lat_q <= (lat_q & IN_ONLY) | (wd & WR_OK);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
      end else if (dir_wr) begin
         dir_q <= IN_ONLY | (wd & WR_OK);
      end
   end

   // R3: latch only moves on a port/latch write
   p_lat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_wr |=> $stable(lat_q));

   // R5: nothing but a direction write (overrides included) alters the direction bits
   p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_wr |=> $stable(dir_q));
endmodule

// File: rtl/gpio_ovr_sync.sv
`timescale 1ns/1ps
module gpio_ovr_sync #(
   parameter int W      = 6,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout
);
   initial begin
      a_stage_range: assert (STAGES >= 2 && STAGES <= 4)
         else $error("synchroniser depth out of range");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];

   generate
      if (STAGES == 2) begin : g_chk2
         logic [1:0] age;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           age <= '0;
            else if (age != 2'd3) age <= age + 2'd1;
         end
         // R4: port level seen two edges after sampling
         p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (age >= 2'd2) |-> (dout == $past(din, 2)));
      end
   endgenerate
endmodule

// File: rtl/gpio_ovr_pin.sv
`timescale 1ns/1ps
module gpio_ovr_pin
   import gpio_ovr_pkg::*;
#(
   parameter pin_kind_e KIND = PIN_PLAIN
) (
   input  logic dir_bit,
   input  logic lat_bit,
   input  logic ovr_req,
   input  logic ovr_oe,
   input  logic ovr_out,
   output logic pad_oe,
   output logic pad_out
);
   generate
      if (KIND == PIN_IN_ONLY) begin : g_in_only
         logic unused_in;
         assign unused_in = dir_bit ^ lat_bit ^ ovr_req ^ ovr_oe ^ ovr_out;
         assign pad_oe  = 1'b0;
         assign pad_out = 1'b0;
      end else if (KIND == PIN_SHARED) begin : g_shared
         assign pad_oe  = ovr_req ? ovr_oe  : ~dir_bit;
         assign pad_out = ovr_req ? ovr_out : lat_bit;
      end else begin : g_plain
         logic unused_ovr;
         assign unused_ovr = ovr_req ^ ovr_oe ^ ovr_out;
         assign pad_oe  = ~dir_bit;
         assign pad_out = lat_bit;
      end
   endgenerate
endmodule

// File: rtl/gpio_ovr_port.sv
`timescale 1ns/1ps
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int          NPINS        = 6,
   parameter logic [7:0]  IN_ONLY_MASK = 8'h20,
   parameter logic [7:0]  SHARED_MASK  = 8'h07,
   parameter int          MCLR_PIN     = 5,
   parameter int          SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  logic              mclr_en,
   input  logic [NPINS-1:0]  ovr_req,
   input  logic [NPINS-1:0]  ovr_oe,
   input  logic [NPINS-1:0]  ovr_out,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out
);
   localparam logic [NPINS-1:0] IN_ONLY = IN_ONLY_MASK[NPINS-1:0];
   localparam logic [NPINS-1:0] MCLR_BIT = NPINS'(1) << MCLR_PIN;

   initial begin
      a_width_ok: assert (NPINS >= 1 && NPINS <= BUS_W)
         else $error("pin count exceeds bus width");
      a_mclr_ok: assert (MCLR_PIN >= 0 && MCLR_PIN < NPINS)
         else $error("master-clear pin out of range");
      a_masks_ok: assert ((IN_ONLY_MASK & SHARED_MASK) == 8'h00)
         else $error("a pin cannot be both input-only and shared");
   end

   logic [NPINS-1:0] lat_q;
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] pin_lvl;
   logic [NPINS-1:0] port_rd;

   gpio_ovr_regs #(
      .NPINS        (NPINS),
      .IN_ONLY_MASK (IN_ONLY_MASK)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .lat_q   (lat_q),
      .dir_q   (dir_q)
   );

   gpio_ovr_sync #(
      .W      (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pin_lvl)
   );

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         localparam pin_kind_e KIND = IN_ONLY_MASK[i] ? PIN_IN_ONLY :
                                      SHARED_MASK[i]  ? PIN_SHARED  : PIN_PLAIN;
         gpio_ovr_pin #(.KIND(KIND)) u_pin (
            .dir_bit (dir_q[i]),
            .lat_bit (lat_q[i]),
            .ovr_req (ovr_req[i]),
            .ovr_oe  (ovr_oe[i]),
            .ovr_out (ovr_out[i]),
            .pad_oe  (pad_oe[i]),
            .pad_out (pad_out[i])
         );
      end
   endgenerate

   assign port_rd = mclr_en ? (pin_lvl & ~MCLR_BIT) : pin_lvl;

   always_comb begin
      rd_data = '0;
      unique case (reg_sel_e'(addr))
         SEL_PORT: rd_data[NPINS-1:0] = port_rd;
         SEL_LAT:  rd_data[NPINS-1:0] = lat_q & ~IN_ONLY;
         SEL_DIR:  rd_data[NPINS-1:0] = dir_q;
         SEL_NONE: rd_data = '0;
         default:  rd_data = '0;
      endcase
   end

   // R7: input-only pins never drive
   p_in_only_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & IN_ONLY) == '0) && ((pad_out & IN_ONLY) == '0));

   // R8: master clear hides the pin level
   p_mclr_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mclr_en && addr == 2'd0) |-> (rd_data[MCLR_PIN] == 1'b0));

   // R9: unused address reads zero
   p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd3) |-> (rd_data == 8'h00));
endmodule

// File: tb/gpio_ovr_port_tb.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [1:0] addr = 0;
   logic       wr_en = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] rd_data;
   logic       mclr_en = 1;
   logic [5:0] ovr_req = 0, ovr_oe = 0, ovr_out = 0, pad_in = 0;
   logic [5:0] pad_oe, pad_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [5:0] m_lat, m_dir;

   always #10 clk = ~clk;

   gpio_ovr_port u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .mclr_en(mclr_en), .ovr_req(ovr_req), .ovr_oe(ovr_oe),
      .ovr_out(ovr_out), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] exp_oe(logic [5:0] dir, logic [5:0] rq, logic [5:0] oe);
      logic [5:0] r;
      for (int i = 0; i < 6; i++) begin
         if (i == 5)                r[i] = 1'b0;
         else if (i < 3 && rq[i])   r[i] = oe[i];
         else                       r[i] = ~dir[i];
      end
      return r;
   endfunction

   function automatic logic [5:0] exp_out(logic [5:0] lat, logic [5:0] rq, logic [5:0] ov);
      logic [5:0] r;
      for (int i = 0; i < 6; i++) begin
         if (i == 5)                r[i] = 1'b0;
         else if (i < 3 && rq[i])   r[i] = ov[i];
         else                       r[i] = lat[i];
      end
      return r;
   endfunction

   function automatic logic [7:0] exp_port(logic [5:0] lvl, logic mc);
      return {2'b00, mc ? 1'b0 : lvl[5], lvl[4:0]};
   endfunction

   task automatic model_write(input logic [1:0] a, input logic [7:0] d);
      if (a == 2'd0 || a == 2'd1) m_lat = d[5:0] & 6'h1F;
      else if (a == 2'd2)         m_dir = (d[5:0] & 6'h1F) | 6'h20;
   endtask

   task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
      model_write(a, d);
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1A));
      m_lat = 6'h00; m_dir = 6'h3F;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      rd_chk("R1 dir", 2'd2, 8'h3F);
      rd_chk("R1 lat", 2'd1, 8'h00);
      chk("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
      rst_n = 1;

      // R9: write to the hole changes nothing
      do_write(2'd3, 8'h00);
      rd_chk("R9 hole read", 2'd3, 8'h00);
      rd_chk("R9 dir kept", 2'd2, 8'h3F);
      rd_chk("R9 lat kept", 2'd1, 8'h00);

      // R3 write via port address; R7 bit 5 ignored
      do_write(2'd0, 8'hFF);
      rd_chk("R3 lat via port addr", 2'd1, 8'h1F);
      do_write(2'd1, 8'h0A);
      rd_chk("R3 lat via lat addr", 2'd1, 8'h0A);
      do_write(2'd2, 8'h00);
      rd_chk("R7 dir bit5 stays", 2'd2, 8'h20);
      chk("R2 pad_oe outputs", {2'b0, pad_oe}, 8'h1F);
      chk("R7 pad_out", {2'b0, pad_out}, 8'h0A);

      // R3: latch read ignores pin level
      pad_in = 6'h35;
      repeat (3) @(negedge clk);
      rd_chk("R3 lat not pins", 2'd1, 8'h0A);

      // R10: not visible before the edge
      @(negedge clk);
      addr = 2'd1; wr_data = 8'h15; wr_en = 1;
      #1 chk("R10 before edge", rd_data, 8'h0A);
      @(negedge clk);
      wr_en = 0; model_write(2'd1, 8'h15);
      #1 chk("R10 after edge", rd_data, 8'h15);

      // R4 two-edge delay; R8 master clear
      mclr_en = 0;
      @(negedge clk);
      pad_in = 6'h2A; addr = 2'd0;
      #1 chk("R4 before", rd_data, 8'h35);
      @(negedge clk);
      #1 chk("R4 one edge", rd_data, 8'h35);
      @(negedge clk);
      #1 chk("R4 two edges", rd_data, 8'h2A);
      mclr_en = 1;
      #1 chk("R8 mclr hides bit5", rd_data, 8'h0A);

      // R5 override pins 0..2, dir unaffected; R6 pins 3..5 ignored
      do_write(2'd2, 8'h1B);
      @(negedge clk);
      ovr_req = 6'h3F; ovr_oe = 6'h3C; ovr_out = 6'h3D;
      #1;
      chk("R5/R6 pad_oe", {2'b0, pad_oe}, {2'b0, exp_oe(m_dir, ovr_req, ovr_oe)});
      chk("R5/R6 pad_out", {2'b0, pad_out}, {2'b0, exp_out(m_lat, ovr_req, ovr_out)});
      @(negedge clk);
      rd_chk("R5 dir unchanged", 2'd2, {2'b0, m_dir});
      ovr_req = 0;

      // random mix
      for (int it = 0; it < 300; it++) begin
         logic [1:0] a;
         logic [7:0] d;
         @(negedge clk);
         a = 2'($urandom_range(0, 3));
         d = 8'($urandom);
         addr = a; wr_data = d; wr_en = ($urandom_range(0, 3) != 0);
         ovr_req = 6'($urandom); ovr_oe = 6'($urandom); ovr_out = 6'($urandom);
         pad_in = 6'($urandom); mclr_en = 1'($urandom);
         @(negedge clk);
         if (wr_en) model_write(a, d);
         wr_en = 0;
         #1;
         chk("R2/R5/R6/R7 rnd oe", {2'b0, pad_oe}, {2'b0, exp_oe(m_dir, ovr_req, ovr_oe)});
         chk("R2/R5/R6/R7 rnd out", {2'b0, pad_out}, {2'b0, exp_out(m_lat, ovr_req, ovr_out)});
         @(negedge clk);
         rd_chk("R4/R8 rnd port", 2'd0, exp_port(pad_in, mclr_en));
         rd_chk("R3 rnd lat", 2'd1, {2'b0, m_lat});
         rd_chk("R5 rnd dir", 2'd2, {2'b0, m_dir});
         rd_chk("R9 rnd hole", 2'd3, 8'h00);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule